// File: doc/BRIEF.md
# Bus Command Receiver and Decoder

This block takes words one at a time from an on-chip bus receive FIFO. A word read while the address-valid flag is high names the sender. The words after it are that sender's payload. The first payload word is a command header, and its top four bits select one of four operations:

- **Transmit configuration.** The block gathers four words into timeout, destination IP, port pair and response address. It hands them, with the sender as lock owner, to a control register block, marked by a one-cycle strobe.
- **Receive configuration.** Same fields without the timeout, marked by its own strobe.
- **Data transmit.** Checked against the current lock owner. An accepted transmit raises a request carrying its byte length, waits for the transmit controller to acknowledge, and then splits the payload into 16-bit writes to a transmit FIFO.
- **Lock release.** Checked against the current lock owner and turned into a one-cycle release pulse.

Rejected and unknown transfers are drained without side effects.

The read-enable toward the bus FIFO is a combinational function of the decoder state and the transmit FIFO's full flag. A word is consumed on every rising edge where read-enable is high and the FIFO is not empty. All other outputs are registered.

Top module: `cmd_rx_decoder`

## Requirements
- R1: A word is consumed only on a rising edge where `in_re` is 1 and `in_empty` is 0. A consumed word with `in_av` = 1 becomes the sender address, and the next consumed word with `in_av` = 0 is the command header.
- R2: Header bits 31:28 = 0x0 start a transmit configuration of four words. The fields are: word 0 bits 15:0 timeout, word 1 destination IP, word 2 bits 31:16 destination port and bits 15:0 source port, word 3 response address. One cycle after word 3 is consumed, `tx_cfg_stb` is 1 for one cycle with all fields valid and `cfg_lock_addr` equal to the sender.
- R3: Header bits 31:28 = 0x3 start a receive configuration with words 1 to 3 laid out as in R2. It ends with a one-cycle `rx_cfg_stb` and leaves `cfg_timeout` unchanged.
- R4: A transmit configuration is forwarded whatever the values of `lock_in` and `lock_addr_in`.
- R5: Header bits 31:28 = 0x1 is a data transmit with byte length in bits 27:17. When `lock_in` = 1 and the sender equals `lock_addr_in`, `tx_len` shows the length and `tx_req` rises one cycle after the header. `tx_req` stays high with `in_re` low until a cycle with `tx_ack` = 1.
- R6: A data transmit that fails the owner check raises no `tx_req` and writes nothing. Its payload words are consumed and discarded until the next address word.
- R7: After the acknowledge, each payload word produces 16-bit writes: bits 15:0 first, then bits 31:16. The total is ceil(length/2) writes, so an odd count of halves drops the last upper half.
- R8: Header bits 31:28 = 0x2 pulse `release_stb` for one cycle only when `lock_in` = 1 and the sender equals `lock_addr_in`. A release from any other sender is ignored.
- R9: No write is issued on an edge where `fifo_full` is 1. While a transmit is waiting on space, `in_re` stays low.
- R10: Any other header nibble raises no strobe and no request. The rest of that transfer is drained up to the next address word.
- R11: While `rst` is 1, `in_re` is 0. After a reset edge, all strobes, `tx_req` and `fifo_we` are 0.
- R12: At most one of `tx_cfg_stb`, `rx_cfg_stb` and `release_stb` is high in a cycle, and none is high two cycles running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | DW | Word at the head of the bus FIFO |
| in_av | input | 1 | Head word is a sender address |
| in_empty | input | 1 | Bus FIFO is empty |
| in_re | output | 1 | Read-enable toward the bus FIFO |
| lock_in | input | 1 | Control registers hold a lock |
| lock_addr_in | input | AW | Current lock owner |
| tx_ack | input | 1 | Transmit controller accepts the request |
| fifo_full | input | 1 | Transmit FIFO cannot take a write |
| tx_req | output | 1 | New transmit request |
| tx_len | output | LENW | Transmit length in bytes |
| fifo_data | output | DW/2 | 16-bit word to the transmit FIFO |
| fifo_we | output | 1 | Write strobe to the transmit FIFO |
| tx_cfg_stb | output | 1 | Transmit configuration is valid |
| rx_cfg_stb | output | 1 | Receive configuration is valid |
| release_stb | output | 1 | Lock release pulse |
| cfg_timeout | output | TW | Timeout field |
| cfg_ip | output | DW | Destination IP address |
| cfg_dst_port | output | DW/2 | Destination port |
| cfg_src_port | output | DW/2 | Source port |
| cfg_resp_addr | output | AW | Response bus address |
| cfg_lock_addr | output | AW | Sender of the configuration |

## Verification
Timing of results relative to their stimulus:

- **Strobes, request and length.** These are due on the first edge after the word that completes them is consumed. The bench feeds each word by holding it until it sees `in_re` high at a falling edge and then lets one rising edge pass, so it reads these outputs at the falling edge straight after that push.
- **Request low.** `tx_req` falls on the edge that samples `tx_ack`, and it is read one half-cycle later.
- **FIFO writes.** The two 16-bit writes of a word follow on the first and second edges after it is consumed, or later while `fifo_full` holds. A falling-edge monitor therefore logs every write, and the log is compared only after enough idle cycles have passed for all writes to have drained.

// File: rtl/cmd_rx_pkg.sv
package cmd_rx_pkg;

  typedef enum logic [2:0] {
    ST_ADDR,
    ST_HDR,
    ST_CFG,
    ST_REQ,
    ST_PAY
  } rx_state_e;

  localparam logic [3:0] OP_TXCFG   = 4'h0;
  localparam logic [3:0] OP_DATA    = 4'h1;
  localparam logic [3:0] OP_RELEASE = 4'h2;
  localparam logic [3:0] OP_RXCFG   = 4'h3;

endpackage

// File: rtl/cmd_rx_owner_match.sv
module cmd_rx_owner_match #(
  parameter int AW = 32
) (
  input  logic          lock_in,
  input  logic [AW-1:0] lock_addr,
  input  logic [AW-1:0] sender,
  output logic          owner_ok
);

  assign owner_ok = lock_in && (sender == lock_addr);

endmodule

// File: rtl/cmd_rx_cfg_capture.sv
module cmd_rx_cfg_capture #(
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_en,
  input  logic [1:0]    cap_idx,
  input  logic          cap_is_rx,
  input  logic [DW-1:0] cap_word,
  input  logic [AW-1:0] cap_sender,
  output logic          tx_stb,
  output logic          rx_stb,
  output logic [TW-1:0] timeout,
  output logic [DW-1:0] ip,
  output logic [DW/2-1:0] dst_port,
  output logic [DW/2-1:0] src_port,
  output logic [AW-1:0] resp_addr,
  output logic [AW-1:0] lock_addr
);

  localparam int PW = DW / 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_stb    <= 1'b0;
      rx_stb    <= 1'b0;
      timeout   <= '0;
      ip        <= '0;
      dst_port  <= '0;
      src_port  <= '0;
      resp_addr <= '0;
      lock_addr <= '0;
    end else begin
      tx_stb <= 1'b0;
      rx_stb <= 1'b0;
      if (cap_en) begin
        unique case (cap_idx)
          2'd0: timeout <= cap_word[TW-1:0];
          2'd1: ip <= cap_word;
          2'd2: begin
            dst_port <= cap_word[DW-1:PW];
            src_port <= cap_word[PW-1:0];
          end
          default: begin
            resp_addr <= cap_word[AW-1:0];
            lock_addr <= cap_sender;
            tx_stb    <= !cap_is_rx;
            rx_stb    <= cap_is_rx;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/cmd_rx_splitter.sv
module cmd_rx_splitter #(
  parameter int DW   = 32,
  parameter int LENW = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [LENW-1:0] halves_in,
  input  logic            word_valid,
  input  logic [DW-1:0]   word_in,
  input  logic            fifo_full,
  output logic            need_word,
  output logic            busy,
  output logic [DW/2-1:0] fifo_data,
  output logic            fifo_we
);

  localparam int HW = DW / 2;

  logic [LENW-1:0] halves_left;
  logic [LENW-1:0] words_left;
  logic [DW-1:0]   buf_q;
  logic            buf_valid;
  logic            phase;
  logic [LENW:0]   halves_plus;

  assign halves_plus = {1'b0, halves_in} + 1'b1;
  assign need_word   = (words_left != '0) && !buf_valid && !fifo_full;
  assign busy        = (halves_left != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      halves_left <= '0;
      words_left  <= '0;
      buf_q       <= '0;
      buf_valid   <= 1'b0;
      phase       <= 1'b0;
      fifo_data   <= '0;
      fifo_we     <= 1'b0;
    end else begin
      fifo_we <= 1'b0;
      if (start) begin
        halves_left <= halves_in;
        words_left  <= halves_plus[LENW:1];
        buf_valid   <= 1'b0;
        phase       <= 1'b0;
      end else if (word_valid && need_word) begin
        buf_q      <= word_in;
        buf_valid  <= 1'b1;
        phase      <= 1'b0;
        words_left <= words_left - LENW'(1);
      end else if (buf_valid && !fifo_full) begin
        fifo_we     <= 1'b1;
        fifo_data   <= phase ? buf_q[DW-1:HW] : buf_q[HW-1:0];
        halves_left <= halves_left - LENW'(1);
        phase       <= 1'b1;
        if (phase || halves_left == LENW'(1)) begin
          buf_valid <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/cmd_rx_decoder.sv
module cmd_rx_decoder
  import cmd_rx_pkg::*;
#(
  parameter int DW   = 32,
  parameter int AW   = 32,
  parameter int TW   = 16,
  parameter int LENW = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DW-1:0]     in_data,
  input  logic              in_av,
  input  logic              in_empty,
  output logic              in_re,
  input  logic              lock_in,
  input  logic [AW-1:0]     lock_addr_in,
  input  logic              tx_ack,
  input  logic              fifo_full,
  output logic              tx_req,
  output logic [LENW-1:0]   tx_len,
  output logic [DW/2-1:0]   fifo_data,
  output logic              fifo_we,
  output logic              tx_cfg_stb,
  output logic              rx_cfg_stb,
  output logic              release_stb,
  output logic [TW-1:0]     cfg_timeout,
  output logic [DW-1:0]     cfg_ip,
  output logic [DW/2-1:0]   cfg_dst_port,
  output logic [DW/2-1:0]   cfg_src_port,
  output logic [AW-1:0]     cfg_resp_addr,
  output logic [AW-1:0]     cfg_lock_addr
);

  localparam int LEN_HI = DW - 5;
  localparam int LEN_LO = DW - 4 - LENW;

  rx_state_e       state_q;
  logic [AW-1:0]   sender_q;
  logic [1:0]      cfg_idx_q;
  logic            cfg_rx_q;
  logic            tx_req_q;
  logic [LENW-1:0] tx_len_q;
  logic            rel_q;

  logic            take;
  logic [3:0]      op;
  logic            owner_ok;
  logic            need_word;
  logic            split_busy;
  logic            split_start;
  logic [LENW:0]   len_plus;
  logic [LENW-1:0] halves;
  logic            cap_en;
  logic [1:0]      cap_idx;
  logic            cap_is_rx;

  assign take     = in_re && !in_empty;
  assign op       = in_data[DW-1 -: 4];
  assign len_plus = {1'b0, tx_len_q} + 1'b1;
  assign halves   = len_plus[LENW:1];
  assign split_start = (state_q == ST_REQ) && tx_ack;

  always_comb begin
    in_re = 1'b0;
    if (!rst) begin
      unique case (state_q)
        ST_ADDR, ST_HDR, ST_CFG: in_re = 1'b1;
        ST_PAY:                  in_re = need_word;
        default:                 in_re = 1'b0;
      endcase
    end
  end

  always_comb begin
    cap_en    = 1'b0;
    cap_idx   = cfg_idx_q;
    cap_is_rx = cfg_rx_q;
    if (take && !in_av) begin
      if (state_q == ST_HDR && op == OP_TXCFG) begin
        cap_en    = 1'b1;
        cap_idx   = 2'd0;
        cap_is_rx = 1'b0;
      end else if (state_q == ST_CFG) begin
        cap_en = 1'b1;
      end
    end
  end

  cmd_rx_owner_match #(.AW(AW)) i_owner (
    .lock_in   (lock_in),
    .lock_addr (lock_addr_in),
    .sender    (sender_q),
    .owner_ok  (owner_ok)
  );

  cmd_rx_cfg_capture #(.DW(DW), .AW(AW), .TW(TW)) i_cfg (
    .clk        (clk),
    .rst        (rst),
    .cap_en     (cap_en),
    .cap_idx    (cap_idx),
    .cap_is_rx  (cap_is_rx),
    .cap_word   (in_data),
    .cap_sender (sender_q),
    .tx_stb     (tx_cfg_stb),
    .rx_stb     (rx_cfg_stb),
    .timeout    (cfg_timeout),
    .ip         (cfg_ip),
    .dst_port   (cfg_dst_port),
    .src_port   (cfg_src_port),
    .resp_addr  (cfg_resp_addr),
    .lock_addr  (cfg_lock_addr)
  );

  cmd_rx_splitter #(.DW(DW), .LENW(LENW)) i_split (
    .clk        (clk),
    .rst        (rst),
    .start      (split_start),
    .halves_in  (halves),
    .word_valid (take && state_q == ST_PAY),
    .word_in    (in_data),
    .fifo_full  (fifo_full),
    .need_word  (need_word),
    .busy       (split_busy),
    .fifo_data  (fifo_data),
    .fifo_we    (fifo_we)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_ADDR;
      sender_q  <= '0;
      cfg_idx_q <= '0;
      cfg_rx_q  <= 1'b0;
      tx_req_q  <= 1'b0;
      tx_len_q  <= '0;
      rel_q     <= 1'b0;
    end else begin
      rel_q <= 1'b0;
      unique case (state_q)
        ST_ADDR: begin
          if (take && in_av) begin
            sender_q <= in_data[AW-1:0];
            state_q  <= ST_HDR;
          end
        end
        ST_HDR: begin
          if (take) begin
            if (in_av) begin
              sender_q <= in_data[AW-1:0];
            end else begin
              unique case (op)
                OP_TXCFG: begin
                  cfg_rx_q  <= 1'b0;
                  cfg_idx_q <= 2'd1;
                  state_q   <= ST_CFG;
                end
                OP_RXCFG: begin
                  cfg_rx_q  <= 1'b1;
                  cfg_idx_q <= 2'd1;
                  state_q   <= ST_CFG;
                end
                OP_DATA: begin
                  if (owner_ok) begin
                    tx_len_q <= in_data[LEN_HI:LEN_LO];
                    tx_req_q <= 1'b1;
                    state_q  <= ST_REQ;
                  end else begin
                    state_q <= ST_ADDR;
                  end
                end
                OP_RELEASE: begin
                  rel_q   <= owner_ok;
                  state_q <= ST_ADDR;
                end
                default: state_q <= ST_ADDR;
              endcase
            end
          end
        end
        ST_CFG: begin
          if (take) begin
            if (in_av) begin
              sender_q <= in_data[AW-1:0];
              state_q  <= ST_HDR;
            end else if (cfg_idx_q == 2'd3) begin
              state_q <= ST_ADDR;
            end else begin
              cfg_idx_q <= cfg_idx_q + 2'd1;
            end
          end
        end
        ST_REQ: begin
          if (tx_ack) begin
            tx_req_q <= 1'b0;
            state_q  <= ST_PAY;
          end
        end
        ST_PAY: begin
          if (!split_busy) begin
            state_q <= ST_ADDR;
          end
        end
        default: state_q <= ST_ADDR;
      endcase
    end
  end

  assign tx_req      = tx_req_q;
  assign tx_len      = tx_len_q;
  assign release_stb = rel_q;

endmodule

// File: rtl/cmd_rx_checker.sv
module cmd_rx_checker (
  input logic clk,
  input logic rst,
  input logic in_re,
  input logic tx_cfg_stb,
  input logic rx_cfg_stb,
  input logic release_stb,
  input logic tx_req,
  input logic tx_ack,
  input logic fifo_we,
  input logic fifo_full,
  input logic lock_in
);

  // R11: read-enable is held low during reset
  always_comb begin
    if (rst) begin
      a_r11_re_low: assert (!in_re);
    end
  end

  // R11: a reset edge clears the request, the writes and every strobe
  a_r11_reset_clear: assert property (@(posedge clk)
    rst |=> (!tx_req && !fifo_we && !tx_cfg_stb && !rx_cfg_stb && !release_stb));

  // R5: the request holds until acknowledged
  a_r5_req_hold: assert property (@(posedge clk) disable iff (rst)
    (tx_req && !tx_ack) |=> tx_req);

  // R5: a request only rises while a lock is held
  a_r5_req_locked: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_req) |-> $past(lock_in));

  // R8: a release pulse only follows a cycle with the lock held
  a_r8_release_locked: assert property (@(posedge clk) disable iff (rst)
    release_stb |-> $past(lock_in));

  // R9: no write is issued on an edge that saw the FIFO full
  a_r9_no_write_full: assert property (@(posedge clk) disable iff (rst)
    fifo_we |-> !$past(fifo_full));

  // R12: strobes are exclusive single-cycle pulses
  a_r12_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tx_cfg_stb, rx_cfg_stb, release_stb}));

  a_r12_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (tx_cfg_stb || rx_cfg_stb || release_stb) |=>
      !(tx_cfg_stb || rx_cfg_stb || release_stb));

endmodule

bind cmd_rx_decoder cmd_rx_checker i_chk (
  .clk         (clk),
  .rst         (rst),
  .in_re       (in_re),
  .tx_cfg_stb  (tx_cfg_stb),
  .rx_cfg_stb  (rx_cfg_stb),
  .release_stb (release_stb),
  .tx_req      (tx_req),
  .tx_ack      (tx_ack),
  .fifo_we     (fifo_we),
  .fifo_full   (fifo_full),
  .lock_in     (lock_in)
);

// File: tb/test_cmd_rx_decoder.sv
`timescale 1ns/1ps
module test_cmd_rx_decoder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] in_data = '0;
  logic        in_av = 1'b0;
  logic        in_empty = 1'b1;
  logic        in_re;
  logic        lock_in = 1'b0;
  logic [31:0] lock_addr_in = '0;
  logic        tx_ack = 1'b0;
  logic        fifo_full = 1'b0;
  logic        tx_req;
  logic [10:0] tx_len;
  logic [15:0] fifo_data;
  logic        fifo_we;
  logic        tx_cfg_stb, rx_cfg_stb, release_stb;
  logic [15:0] cfg_timeout;
  logic [31:0] cfg_ip;
  logic [15:0] cfg_dst_port, cfg_src_port;
  logic [31:0] cfg_resp_addr, cfg_lock_addr;

  int checks = 0;
  int fails  = 0;
  logic [15:0] cap [0:63];
  int ncap = 0;

  localparam logic [31:0] SA = 32'h01234567;
  localparam logic [31:0] SB = 32'h01010101;

  // sender, header, lock, lock owner, expect request, expect release
  localparam logic [98:0] VEC [0:7] = '{
    {SA,            32'h2fffffff, 1'b1, SA, 1'b0, 1'b1},
    {SA,            32'h2fffffff, 1'b0, SA, 1'b0, 1'b0},
    {32'h0123ffff,  32'h20000000, 1'b1, SA, 1'b0, 1'b0},
    {SA,            32'h10000000, 1'b1, SA, 1'b1, 1'b0},
    {SB,            32'h10000000, 1'b1, SA, 1'b0, 1'b0},
    {SA,            32'h10000000, 1'b0, SA, 1'b0, 1'b0},
    {SA,            32'h5abcdef0, 1'b1, SA, 1'b0, 1'b0},
    {SA,            32'hf0000000, 1'b1, SA, 1'b0, 1'b0}
  };

  always #2.5 clk = ~clk;

  cmd_rx_decoder i_cmd_rx_decoder (
    .clk(clk), .rst(rst), .in_data(in_data), .in_av(in_av), .in_empty(in_empty),
    .in_re(in_re), .lock_in(lock_in), .lock_addr_in(lock_addr_in), .tx_ack(tx_ack),
    .fifo_full(fifo_full), .tx_req(tx_req), .tx_len(tx_len), .fifo_data(fifo_data),
    .fifo_we(fifo_we), .tx_cfg_stb(tx_cfg_stb), .rx_cfg_stb(rx_cfg_stb),
    .release_stb(release_stb), .cfg_timeout(cfg_timeout), .cfg_ip(cfg_ip),
    .cfg_dst_port(cfg_dst_port), .cfg_src_port(cfg_src_port),
    .cfg_resp_addr(cfg_resp_addr), .cfg_lock_addr(cfg_lock_addr)
  );

  always @(negedge clk) begin
    if (fifo_we && ncap < 64) begin
      cap[ncap] = fifo_data;
      ncap = ncap + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w, input logic av);
    in_data  = w;
    in_av    = av;
    in_empty = 1'b0;
    while (!in_re) @(negedge clk);
    @(negedge clk);
    in_empty = 1'b1;
    in_av    = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack_pulse();
    tx_ack = 1'b1;
    @(negedge clk);
    tx_ack = 1'b0;
  endtask

  task automatic no_strobes(input string req);
    chk(req, {29'd0, tx_cfg_stb, rx_cfg_stb, release_stb}, 32'd0);
    chk(req, {31'd0, tx_req}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R11: reset state
    idle(3);
    chk("R11 in_re", {31'd0, in_re}, 32'd0);
    chk("R11 tx_req", {31'd0, tx_req}, 32'd0);
    chk("R11 fifo_we", {31'd0, fifo_we}, 32'd0);
    no_strobes("R11 strobes");
    rst = 1'b0;
    idle(2);

    // R8 R5 R10: header decode table
    for (int i = 0; i < 8; i++) begin
      lock_in      = VEC[i][34];
      lock_addr_in = VEC[i][33:2];
      push(VEC[i][98:67], 1'b1);
      push(VEC[i][66:35], 1'b0);
      chk("R5 table req", {31'd0, tx_req}, {31'd0, VEC[i][1]});
      chk("R8 table release", {31'd0, release_stb}, {31'd0, VEC[i][0]});
      chk("R10 table cfg strobes", {30'd0, tx_cfg_stb, rx_cfg_stb}, 32'd0);
      if (VEC[i][1]) begin
        chk("R5 table len", {21'd0, tx_len}, 32'd0);
        ack_pulse();
      end
      idle(2);
    end

    // R2 R1: transmit configuration
    lock_in = 1'b0;
    push(SA, 1'b1);
    push(32'h00001234, 1'b0);
    push(32'hacdcabba, 1'b0);
    push(32'h0101aaaa, 1'b0);
    chk("R2 early strobe", {31'd0, tx_cfg_stb}, 32'd0);
    push(32'h0082faac, 1'b0);
    chk("R2 strobe", {31'd0, tx_cfg_stb}, 32'd1);
    chk("R2 timeout", {16'd0, cfg_timeout}, 32'h1234);
    chk("R2 ip", cfg_ip, 32'hacdcabba);
    chk("R2 dst", {16'd0, cfg_dst_port}, 32'h0101);
    chk("R2 src", {16'd0, cfg_src_port}, 32'haaaa);
    chk("R2 resp", cfg_resp_addr, 32'h0082faac);
    chk("R2 owner", cfg_lock_addr, SA);
    idle(1);
    chk("R12 strobe single", {31'd0, tx_cfg_stb}, 32'd0);

    // R4: another sender's configuration while A holds the lock
    lock_in = 1'b1; lock_addr_in = SA;
    push(SB, 1'b1);
    push(32'h00002212, 1'b0);
    push(32'habbacd00, 1'b0);
    push(32'h1010bbbb, 1'b0);
    push(32'h0080beba, 1'b0);
    chk("R4 forwarded", {31'd0, tx_cfg_stb}, 32'd1);
    chk("R4 owner is sender", cfg_lock_addr, SB);

    // R3: receive configuration
    push(32'h14235867, 1'b1);
    push(32'h30f0f0f0, 1'b0);
    push(32'h0f00130b, 1'b0);
    push(32'h33334444, 1'b0);
    push(32'h00112233, 1'b0);
    chk("R3 rx strobe", {31'd0, rx_cfg_stb}, 32'd1);
    chk("R3 no tx strobe", {31'd0, tx_cfg_stb}, 32'd0);
    chk("R3 ip", cfg_ip, 32'h0f00130b);
    chk("R3 ports", {cfg_dst_port, cfg_src_port}, 32'h33334444);
    chk("R3 resp", cfg_resp_addr, 32'h00112233);
    chk("R3 timeout kept", {16'd0, cfg_timeout}, 32'h2212);

    // R5 R7: 11-byte transmit
    ncap = 0;
    push(SA, 1'b1);
    push(32'h10160000, 1'b0);
    chk("R5 req", {31'd0, tx_req}, 32'd1);
    chk("R5 len", {21'd0, tx_len}, 32'd11);
    idle(3);
    chk("R5 req held", {31'd0, tx_req}, 32'd1);
    chk("R5 re low waiting", {31'd0, in_re}, 32'd0);
    ack_pulse();
    chk("R5 req cleared", {31'd0, tx_req}, 32'd0);
    push(32'h03020100, 1'b0);
    push(32'h07060504, 1'b0);
    push(32'h0b0a0908, 1'b0);
    idle(4);
    chk("R7 count 11B", ncap, 32'd6);
    for (int k = 0; k < 6; k++)
      chk("R7 order 11B", {16'd0, cap[k]}, {16'd0, 8'(2*k+1), 8'(2*k)});

    // R7 R1: 5-byte transmit, odd half count, trailing word drained
    ncap = 0;
    push(SA, 1'b1);
    push(32'h100a0000, 1'b0);
    ack_pulse();
    push(32'h11112222, 1'b0);
    push(32'h33334444, 1'b0);
    idle(4);
    push(32'h55556666, 1'b0);
    idle(4);
    chk("R7 count 5B", ncap, 32'd3);
    chk("R7 w0", {16'd0, cap[0]}, 32'h2222);
    chk("R7 w1", {16'd0, cap[1]}, 32'h1111);
    chk("R7 w2", {16'd0, cap[2]}, 32'h4444);

    // R7: 72-byte transmit
    ncap = 0;
    push(SA, 1'b1);
    push(32'h10900000, 1'b0);
    chk("R5 len 72", {21'd0, tx_len}, 32'd72);
    ack_pulse();
    for (int k = 0; k < 18; k++) push({16'(2*k+1), 16'(2*k)}, 1'b0);
    idle(4);
    chk("R7 count 72B", ncap, 32'd36);
    for (int k = 0; k < 36; k++) chk("R7 seq 72B", {16'd0, cap[k]}, k);

    // R9: full stalls writes and reads
    ncap = 0;
    push(SA, 1'b1);
    push(32'h10100000, 1'b0);
    ack_pulse();
    push(32'haaaabbbb, 1'b0);
    fifo_full = 1'b1;
    idle(4);
    chk("R9 no write full", ncap, 32'd0);
    chk("R9 re low full", {31'd0, in_re}, 32'd0);
    fifo_full = 1'b0;
    push(32'hccccdddd, 1'b0);
    idle(4);
    chk("R9 count after", ncap, 32'd4);
    chk("R9 order", {cap[0], cap[1]}, 32'hbbbbaaaa);
    chk("R9 order2", {cap[2], cap[3]}, 32'hddddcccc);

    // R6: non-owner transmit drained
    ncap = 0;
    push(SB, 1'b1);
    push(32'h10100000, 1'b0);
    no_strobes("R6 rejected");
    push(32'h12345678, 1'b0);
    push(32'h9abcdef0, 1'b0);
    idle(4);
    chk("R6 no writes", ncap, 32'd0);
    chk("R6 no req", {31'd0, tx_req}, 32'd0);

    // R10: unknown nibble drained, next transfer works
    push(SA, 1'b1);
    push(32'h7000ffff, 1'b0);
    no_strobes("R10 unknown");
    push(32'h20000000, 1'b0);
    no_strobes("R10 drained word");
    push(SA, 1'b1);
    push(32'h20000000, 1'b0);
    chk("R10 recover release", {31'd0, release_stb}, 32'd1);

    // R11: reset in the middle of a request
    push(SA, 1'b1);
    push(32'h10000000, 1'b0);
    chk("R11 req before", {31'd0, tx_req}, 32'd1);
    rst = 1'b1;
    idle(1);
    chk("R11 req cleared", {31'd0, tx_req}, 32'd0);
    chk("R11 re low", {31'd0, in_re}, 32'd0);
    rst = 1'b0;
    idle(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule